// File: doc/BRIEF.md
# Self-Timed Page Program Sequencer

This block runs the internal program cycle of a small serial-memory controller once the bus side has accepted a complete write. A one-cycle start pulse hands it a byte count and a base address. It then walks the page buffer from index zero upward and commits one byte per fixed-length slot.

Each slot has two halves. The first half ends with an erase strobe, which writes 0xFF to the target location. The second half ends with a write strobe, which stores the buffered byte at the same location. The total cycle therefore grows linearly with the number of bytes held in the buffer.

A busy output stays high for the whole cycle. The bus engine uses busy to withhold acknowledges, so a master can poll for completion. Cell timing is modelled by a slot counter whose length, in system-clock cycles, is a parameter. The target address is the base plus the byte index. Only its low eight bits advance, so a cycle never leaves the 256-byte block selected by the upper address bits.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, busy_o and mem_we_o are 0.
- R2: A start pulse taken while idle with a count from 1 to PAGE_BYTES raises busy_o in the cycle after the pulse.
- R3: A start pulse with a count of 0, or a count above PAGE_BYTES, is ignored. busy_o stays 0 and no write strobe is issued.
- R4: A start pulse that arrives while busy_o is 1 is ignored. The running cycle keeps its length, its addresses and its data.
- R5: busy_o stays high for exactly N × SLOT_CYCLES cycles. It falls in the cycle after the last byte's write strobe.
- R6: Slot i has exactly two strobes, counting offsets from 0 at the slot's first busy cycle. At offset SLOT_CYCLES/2−1, mem_we_o is 1 and mem_wdata_o is 0xFF (erase). At offset SLOT_CYCLES−1, mem_we_o is 1 and mem_wdata_o is the buffered byte (write). mem_we_o is 0 in every other cycle.
- R7: Bytes are committed in arrival order. During slot i, buf_idx_o equals i.
- R8: Both strobes of slot i target the address whose upper bits equal those of base_i. Its low eight bits equal (base_i[7:0] + i) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a program cycle |
| count_i | input | CNT_W | Number of buffered bytes to commit |
| base_i | input | ADDR_W | First target address; the upper bits select the block |
| buf_idx_o | output | IDX_W | Page buffer read index |
| buf_data_i | input | 8 | Page buffer byte at buf_idx_o |
| busy_o | output | 1 | High while a program cycle is in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array target address |
| mem_wdata_o | output | 8 | Array write data (0xFF while erasing) |

## Verification
Every byte count from 1 to the page size is run against four base addresses. One base starts at the bottom of a block. Two sit just below the 256-byte boundary in each block, so the low-byte wraparound is checked apart from the block bits. One is an interior address in the upper block.

Each cycle of every run is compared with arithmetic expectations for busy, buffer index, strobe placement, address and data. A fault in slot length, erase/write ordering or index stepping shows up at a specific cycle. Some runs receive a second start pulse mid-cycle with a different base and count, which tells a truly ignored request apart from one that restarts or retargets the cycle. Out-of-range counts from idle show that no cycle begins.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    STB_NONE  = 2'd0,
    STB_ERASE = 2'd1,
    STB_WRITE = 2'd2
  } strobe_e;

  // A count is usable when it is non-zero and fits the page.
  function automatic logic count_in_range(input int unsigned cnt, input int unsigned page);
    return (cnt != 0) && (cnt <= page);
  endfunction

endpackage

// File: rtl/pps_slot_timer.sv
module pps_slot_timer #(
  parameter int SLOT_CYCLES = 100000,
  localparam int TICK_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1,
  localparam int HALF = SLOT_CYCLES / 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output pps_pkg::strobe_e strobe,
  output logic slot_end
);
  import pps_pkg::*;

  logic [TICK_W-1:0] tick_q;
  logic at_erase, at_write;

  function automatic logic [TICK_W-1:0] tick_next(input logic [TICK_W-1:0] t, input logic wrap);
    return wrap ? '0 : t + 1'b1;
  endfunction

  assign at_erase = run && (tick_q == TICK_W'(HALF - 1));
  assign at_write = run && (tick_q == TICK_W'(SLOT_CYCLES - 1));
  assign slot_end = at_write;

  always_comb begin
    if (at_write)      strobe = STB_WRITE;
    else if (at_erase) strobe = STB_ERASE;
    else               strobe = STB_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tick_q <= '0;
    else if (!run) tick_q <= '0;
    else           tick_q <= tick_next(tick_q, at_write);
  end

  // R6
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe == STB_WRITE) |=> (strobe == STB_NONE) || !run);

endmodule

// File: rtl/pps_byte_stepper.sv
module pps_byte_stepper #(
  parameter int PAGE_BYTES = 8,
  localparam int IDX_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1,
  localparam int CNT_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             advance,
  input  logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  function automatic logic is_final(input logic [IDX_W-1:0] i, input logic [CNT_W-1:0] c);
    return (CNT_W'(i) + CNT_W'(1)) == c;
  endfunction

  assign last = is_final(idx, count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx <= '0;
    else if (clear)            idx <= '0;
    else if (advance && !last) idx <= idx + 1'b1;
  end

  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (CNT_W'(idx) < count));

endmodule

// File: rtl/pps_addr_gen.sv
module pps_addr_gen #(
  parameter int BLOCK_BITS = 1,
  parameter int IDX_W = 3,
  localparam int ADDR_W = 8 + BLOCK_BITS
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);

  // Only the low byte advances; block bits pass through unchanged.
  function automatic logic [ADDR_W-1:0] target(input logic [ADDR_W-1:0] b, input logic [IDX_W-1:0] i);
    logic [7:0] low;
    low = b[7:0] + 8'(i);
    return {b[ADDR_W-1:8], low};
  endfunction

  assign addr = target(base, idx);

endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
  parameter int PAGE_BYTES = 8,
  parameter int SLOT_CYCLES = 100000,
  parameter int BLOCK_BITS = 1,
  localparam int IDX_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1,
  localparam int CNT_W = $clog2(PAGE_BYTES + 1),
  localparam int ADDR_W = 8 + BLOCK_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [IDX_W-1:0]  buf_idx_o,
  input  logic [7:0]        buf_data_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  import pps_pkg::*;

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              accept, finish, slot_end, last;
  strobe_e           strobe;
  logic [IDX_W-1:0]  idx;

  assign accept = start_i && !busy_q && count_in_range(int'(count_i), PAGE_BYTES);
  assign finish = slot_end && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= count_i;
      base_q <= base_i;
    end else if (finish) begin
      busy_q <= 1'b0;
    end
  end

  pps_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .strobe(strobe), .slot_end(slot_end)
  );

  pps_byte_stepper #(.PAGE_BYTES(PAGE_BYTES)) u_stepper (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy_q), .advance(slot_end),
    .count(cnt_q), .idx(idx), .last(last)
  );

  pps_addr_gen #(.BLOCK_BITS(BLOCK_BITS), .IDX_W(IDX_W)) u_addr (
    .base(base_q), .idx(idx), .addr(mem_addr_o)
  );

  assign buf_idx_o   = idx;
  assign busy_o      = busy_q;
  assign mem_we_o    = (strobe != STB_NONE);
  assign mem_wdata_o = (strobe == STB_WRITE) ? buf_data_i : ERASED_BYTE;

  // R5
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(slot_end && last));

  // R3
  start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_i) && ($past(count_i) != 0) &&
                      ($past(count_i) <= CNT_W'(PAGE_BYTES)));

  // R4
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> $stable(cnt_q) && $stable(base_q));

  // R8
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(mem_addr_o[ADDR_W-1:8]));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_q);

endmodule

// File: tb/page_prog_seq_tb.sv
module page_prog_seq_tb;
  localparam int PAGE = 8;
  localparam int SLOT = 8;
  localparam int CW = $clog2(PAGE + 1);
  localparam int IW = $clog2(PAGE);
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic [AW-1:0] base_i = '0;
  logic [IW-1:0] buf_idx_o;
  logic [7:0] buf_data_i;
  logic busy_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0] mem_wdata_o;
  logic [7:0] pbuf [PAGE];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign buf_data_i = pbuf[buf_idx_o];

  page_prog_seq #(.PAGE_BYTES(PAGE), .SLOT_CYCLES(SLOT), .BLOCK_BITS(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i), .base_i(base_i),
    .buf_idx_o(buf_idx_o), .buf_data_i(buf_data_i), .busy_o(busy_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(input int base, input int n, input bit inject);
    for (int i = 0; i < PAGE; i++) pbuf[i] = 8'((i * 37 + 11) ^ base);
    start_i = 1'b1; count_i = CW'(n); base_i = AW'(base);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < n * SLOT; k++) begin
      int slot = k / SLOT;
      int off = k % SLOT;
      bit er = (off == SLOT / 2 - 1);
      bit wr = (off == SLOT - 1);
      int exp_addr = (base & 256) | (((base % 256) + slot) % 256);
      int exp_data = wr ? int'(pbuf[slot]) : 255;
      chk(busy_o == 1'b1, (k == 0) ? "R2" : "R5", busy_o, 1);
      chk(int'(buf_idx_o) == slot, "R7", buf_idx_o, slot);
      chk(mem_we_o == (er | wr), "R6", mem_we_o, er | wr);
      if (er | wr) begin
        chk(int'(mem_addr_o) == exp_addr, "R8", mem_addr_o, exp_addr);
        chk(int'(mem_wdata_o) == exp_data, "R6", mem_wdata_o, exp_data);
      end
      if (inject && k == 3) begin
        start_i = 1'b1; count_i = CW'(1); base_i = AW'(base ^ 'h0A5);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    // R4: an ignored mid-cycle start must not extend or restart the cycle
    chk(busy_o == 1'b0, inject ? "R4" : "R5", busy_o, 0);
    chk(mem_we_o == 1'b0, "R6", mem_we_o, 0);
    @(negedge clk);
  endtask

  task automatic bad_count(input int n);
    start_i = 1'b1; count_i = CW'(n); base_i = AW'(9'h040);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(busy_o == 1'b0, "R3", busy_o, 0);
      chk(mem_we_o == 1'b0, "R3", mem_we_o, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    int bases [4];
    bases[0] = 'h000; bases[1] = 'h0FE; bases[2] = 'h17A; bases[3] = 'h1FD;
    for (int i = 0; i < PAGE; i++) pbuf[i] = '0;
    @(negedge clk);
    @(negedge clk);
    chk(busy_o == 1'b0, "R1", busy_o, 0);
    chk(mem_we_o == 1'b0, "R1", mem_we_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R1", busy_o, 0);
    bad_count(0);
    bad_count(PAGE + 1);
    bad_count(15);
    for (int b = 0; b < 4; b++)
      for (int n = 1; n <= PAGE; n++)
        run(bases[b], n, (n % 2) == 0);
    bad_count(0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule